// File: doc/BRIEF.md
# Paged and Indirect Data-Address Generator

This block produces the 16-bit data-memory address for each operand access into a 64K-word data space. In paged mode the address is built from a 9-bit page held in a page register (upper bits) and a 7-bit word offset carried by the request (lower bits), so the space reads as 512 pages of 128 words. In pointer modes the address is the contents of one of eight 16-bit pointer registers, chosen by a 3-bit selector register.

After a pointer-mode access the chosen register is post-modified: it steps by one, by the index held in pointer register 0, or by that index with the carry running from the most significant bit down (bit-reversed stepping, used for FFT reordering). In the same access the selector may take a new value. Separate load ports write the page, any pointer register or the selector.

Requests arrive on a valid/ready interface and addresses leave on another. The block holds no buffer: `addr_valid` follows `req_valid` and `req_ready` follows `addr_ready`. A request is taken only in a cycle where both valid and ready are high. While the consumer stalls, the address stays on the output and no register is post-modified.

Top module: `dag_addr_gen`

## Requirements
- R1: Reset clears the page register, the selector and all eight pointer registers to zero.
- R2: With mode 000 (paged), `addr_out[15:7]` is the page register and `addr_out[6:0]` is `req_offset`.
- R3: Mode 001 outputs the selected pointer register unchanged and leaves that register unchanged.
- R4: Mode 010 adds 1 to the selected register after the access and mode 011 subtracts 1. The arithmetic is modulo 2^16.
- R5: Mode 100 adds pointer register 0 to the selected register after the access and mode 101 subtracts it, modulo 2^16.
- R6: Mode 110 adds pointer register 0 and mode 111 subtracts it, with the carry or borrow running from bit 15 toward bit 0.
- R7: In any pointer mode (001 to 111) with `req_ptr_wr` high, the selector takes `req_ptr_val` after the access. In paged mode `req_ptr_wr` has no effect.
- R8: `page_ld`, `ar_ld` and `ptr_ld` write their values on the next edge. A load takes priority over a post-modify or a selector write aimed at the same register in that cycle.
- R9: `addr_valid` equals `req_valid` and `req_ready` equals `addr_ready`. Registers change on a request only in a cycle where both are high, and a stalled address stays stable.
- R10: The address is formed from the register values before the cycle's modify or load. Both take effect on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_mode | input | 3 | Access mode 000..111 |
| req_offset | input | 7 | Word offset within the page |
| req_ptr_wr | input | 1 | Reselect the pointer after this access |
| req_ptr_val | input | 3 | New selector value |
| addr_valid | output | 1 | Address valid |
| addr_ready | input | 1 | Consumer takes the address |
| addr_out | output | 16 | Effective address |
| page_ld | input | 1 | Load the page register |
| page_val | input | 9 | Page value |
| ar_ld | input | 1 | Load a pointer register |
| ar_ld_sel | input | 3 | Pointer register to load |
| ar_ld_val | input | 16 | Value to load |
| ptr_ld | input | 1 | Load the selector |
| ptr_ld_val | input | 3 | Selector value |

## Verification
The hardest cases to reach are the collisions: a load or a selector write landing in the same accepted cycle as a post-modify aimed at the same register. The bench drives both in one cycle, checks that the address still shows the old value, then reads the winner back through a plain pointer-mode access. The bit-reversed carry chains are reached from seeded values, including a reverse borrow out of zero. Every wrap of the plus and minus steps is also driven from a seeded value.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    M_PAGED = 3'b000,
    M_HOLD  = 3'b001,
    M_INC   = 3'b010,
    M_DEC   = 3'b011,
    M_ADDX  = 3'b100,
    M_SUBX  = 3'b101,
    M_RADDX = 3'b110,
    M_RSUBX = 3'b111
  } mode_e;
endpackage

// File: rtl/dag_revcarry.sv
module dag_revcarry #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] ra, rb, rs;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign ra[i] = a[W-1-i];
    assign rb[i] = b[W-1-i];
    assign y[i]  = rs[W-1-i];
  end

  always_comb rs = sub ? (ra - rb) : (ra + rb);
endmodule

// File: rtl/dag_modifier.sv
module dag_modifier
  import dag_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_e        mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] idx,
  output logic [W-1:0] nxt,
  output logic         wr
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] rev_y;

  dag_revcarry #(.W(W)) u_rev (
    .a(cur), .b(idx), .sub(mode == M_RSUBX), .y(rev_y)
  );

  always_comb begin
    wr  = 1'b1;
    nxt = cur;
    unique case (mode)
      M_INC:   nxt = cur + ONE;
      M_DEC:   nxt = cur - ONE;
      M_ADDX:  nxt = cur + idx;
      M_SUBX:  nxt = cur - idx;
      M_RADDX,
      M_RSUBX: nxt = rev_y;
      default: wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/dag_ar_bank.sv
module dag_ar_bank #(
  parameter int W    = 16,
  parameter int N    = 8,
  parameter int SELW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld,
  input  logic [SELW-1:0]     ld_sel,
  input  logic [W-1:0]        ld_val,
  input  logic                mod_en,
  input  logic [SELW-1:0]     mod_sel,
  input  logic [W-1:0]        mod_val,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q[i] <= '0;
      else if (ld && ld_sel == SELW'(i))           q[i] <= ld_val;
      else if (mod_en && mod_sel == SELW'(i))      q[i] <= mod_val;
    end
  end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
  import dag_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 7,
  parameter int NAR  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_mode,
  input  logic [OFFW-1:0]          req_offset,
  input  logic                     req_ptr_wr,
  input  logic [$clog2(NAR)-1:0]   req_ptr_val,
  output logic                     addr_valid,
  input  logic                     addr_ready,
  output logic [AW-1:0]            addr_out,
  input  logic                     page_ld,
  input  logic [AW-OFFW-1:0]       page_val,
  input  logic                     ar_ld,
  input  logic [$clog2(NAR)-1:0]   ar_ld_sel,
  input  logic [AW-1:0]            ar_ld_val,
  input  logic                     ptr_ld,
  input  logic [$clog2(NAR)-1:0]   ptr_ld_val
);
  localparam int PAGEW = AW - OFFW;
  localparam int PTRW  = $clog2(NAR);

  mode_e                  mode;
  logic                   xfer, is_ptr, mod_wr;
  logic [PAGEW-1:0]       page_q;
  logic [PTRW-1:0]        ptr_q;
  logic [NAR-1:0][AW-1:0] ar_q;
  logic [AW-1:0]          sel_val, mod_val;

  assign mode       = mode_e'(req_mode);
  assign req_ready  = addr_ready;
  assign addr_valid = req_valid;
  assign xfer       = req_valid & addr_ready;
  assign is_ptr     = (mode != M_PAGED);
  assign sel_val    = ar_q[ptr_q];

  always_comb begin
    if (is_ptr) addr_out = sel_val;
    else        addr_out = {page_q, req_offset};
  end

  dag_modifier #(.W(AW)) u_mod (
    .mode(mode), .cur(sel_val), .idx(ar_q[0]), .nxt(mod_val), .wr(mod_wr)
  );

  dag_ar_bank #(.W(AW), .N(NAR), .SELW(PTRW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .ld(ar_ld), .ld_sel(ar_ld_sel), .ld_val(ar_ld_val),
    .mod_en(xfer & mod_wr), .mod_sel(ptr_q), .mod_val(mod_val),
    .q(ar_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       page_q <= '0;
    else if (page_ld) page_q <= page_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           ptr_q <= '0;
    else if (ptr_ld)                      ptr_q <= ptr_ld_val;
    else if (xfer && is_ptr && req_ptr_wr) ptr_q <= req_ptr_val;
  end
endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
  parameter int AW   = 16,
  parameter int OFFW = 7,
  parameter int NAR  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     addr_ready,
  input logic [2:0]               req_mode,
  input logic [OFFW-1:0]          req_offset,
  input logic                     req_ptr_wr,
  input logic [$clog2(NAR)-1:0]   req_ptr_val,
  input logic [AW-1:0]            addr_out,
  input logic                     page_ld,
  input logic                     ar_ld,
  input logic [$clog2(NAR)-1:0]   ar_ld_sel,
  input logic [AW-1:0]            ar_ld_val,
  input logic                     ptr_ld,
  input logic [AW-OFFW-1:0]       page_q,
  input logic [$clog2(NAR)-1:0]   ptr_q,
  input logic [NAR-1:0][AW-1:0]   ar_q
);
  logic take;
  assign take = req_valid && addr_ready;

  a_r2_paged_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 3'b000) |->
      (addr_out[OFFW-1:0] == req_offset && addr_out[AW-1:OFFW] == page_q));

  a_r3_ptr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode != 3'b000) |-> addr_out == ar_q[ptr_q]);

  a_r4_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode == 3'b010 && !ar_ld) |=>
      ar_q[$past(ptr_q)] == $past(ar_q[ptr_q]) + AW'(1));

  a_r7_reselect: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_mode != 3'b000 && req_ptr_wr && !ptr_ld) |=>
      ptr_q == $past(req_ptr_val));

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ar_ld |=> ar_q[$past(ar_ld_sel)] == $past(ar_ld_val));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ar_ld && !ptr_ld && !page_ld) |=>
      ($stable(ar_q) && $stable(ptr_q) && $stable(page_q)));
endmodule

bind dag_addr_gen dag_addr_gen_chk #(.AW(AW), .OFFW(OFFW), .NAR(NAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_ready(addr_ready),
  .req_mode(req_mode), .req_offset(req_offset), .req_ptr_wr(req_ptr_wr),
  .req_ptr_val(req_ptr_val), .addr_out(addr_out), .page_ld(page_ld),
  .ar_ld(ar_ld), .ar_ld_sel(ar_ld_sel), .ar_ld_val(ar_ld_val),
  .ptr_ld(ptr_ld), .page_q(page_q), .ptr_q(ptr_q), .ar_q(ar_q)
);

// File: tb/dag_addr_gen_test.sv
`timescale 1ns/1ps
module dag_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ptr_wr = 1'b0, addr_ready = 1'b0;
  logic        req_ready, addr_valid;
  logic [2:0]  req_mode = 3'd0, req_ptr_val = 3'd0;
  logic [6:0]  req_offset = 7'd0;
  logic [15:0] addr_out;
  logic        page_ld = 1'b0, ar_ld = 1'b0, ptr_ld = 1'b0;
  logic [8:0]  page_val = 9'd0;
  logic [2:0]  ar_ld_sel = 3'd0, ptr_ld_val = 3'd0;
  logic [15:0] ar_ld_val = 16'd0;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dag_addr_gen uut (.*);

  // {mode, offset, reselect, new selector, expected address}
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {3'b000, 7'h33, 1'b0, 3'd0, 16'hD2B3}, // R2
    {3'b010, 7'h00, 1'b0, 3'd0, 16'h1000}, // R4
    {3'b001, 7'h00, 1'b0, 3'd0, 16'h1001}, // R3
    {3'b011, 7'h00, 1'b1, 3'd2, 16'h1001}, // R4 R7
    {3'b010, 7'h00, 1'b0, 3'd0, 16'hFFFF}, // R4 wrap up
    {3'b011, 7'h00, 1'b1, 3'd3, 16'h0000}, // R4
    {3'b011, 7'h00, 1'b0, 3'd0, 16'h0000}, // R4 wrap down
    {3'b100, 7'h00, 1'b1, 3'd1, 16'hFFFF}, // R5
    {3'b101, 7'h00, 1'b0, 3'd0, 16'h1000}, // R5
    {3'b001, 7'h00, 1'b1, 3'd3, 16'h0FF8}, // R5 result
    {3'b001, 7'h00, 1'b1, 3'd4, 16'h0007}, // R5 wrap result
    {3'b110, 7'h00, 1'b0, 3'd0, 16'h0010}, // R6
    {3'b110, 7'h00, 1'b0, 3'd0, 16'h0018}, // R6
    {3'b111, 7'h00, 1'b0, 3'd0, 16'h0014}, // R6 reverse carry
    {3'b001, 7'h00, 1'b0, 3'd0, 16'h0018}, // R6 reverse borrow
    {3'b000, 7'h7F, 1'b1, 3'd0, 16'hD2FF}, // R7 ignored in paged
    {3'b001, 7'h00, 1'b0, 3'd0, 16'h0018}, // R7 selector kept
    {3'b001, 7'h00, 1'b1, 3'd5, 16'h0018}, // R7
    {3'b111, 7'h00, 1'b0, 3'd0, 16'h0000}, // R6 borrow from zero
    {3'b001, 7'h00, 1'b0, 3'd0, 16'h000F}  // R6
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic [2:0] m, input logic [6:0] off, input logic pw,
                      input logic [2:0] pv, input logic [15:0] exp, input string rq);
    @(negedge clk);
    req_valid = 1'b1; addr_ready = 1'b1;
    req_mode = m; req_offset = off; req_ptr_wr = pw; req_ptr_val = pv;
    #1 chk(rq, addr_out, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_ptr_wr = 1'b0;
    ar_ld = 1'b0; ptr_ld = 1'b0; page_ld = 1'b0;
  endtask

  task automatic load_ar(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b0; ar_ld = 1'b1; ar_ld_sel = s; ar_ld_val = v;
    @(negedge clk);
    ar_ld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state via ports
    xfer(3'b000, 7'h00, 1'b0, 3'd0, 16'h0000, "R1 page zero");
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'h0000, "R1 pointer zero");
    idle();
    // R8 loads
    page_ld = 1'b1; page_val = 9'h1A5;
    @(negedge clk) page_ld = 1'b0;
    load_ar(3'd0, 16'h0008);
    load_ar(3'd1, 16'h1000);
    load_ar(3'd2, 16'hFFFF);
    load_ar(3'd4, 16'h0010);
    ptr_ld = 1'b1; ptr_ld_val = 3'd1;
    @(negedge clk) ptr_ld = 1'b0;

    for (int i = 0; i < NV; i++)
      xfer(VEC[i][29:27], VEC[i][26:20], VEC[i][19], VEC[i][18:16], VEC[i][15:0],
           "R2-table");
    idle();

    // R8 R10: load and post-modify on the same register, same cycle
    @(negedge clk);
    req_valid = 1'b1; addr_ready = 1'b1; req_mode = 3'b010; req_ptr_wr = 1'b0;
    ar_ld = 1'b1; ar_ld_sel = 3'd5; ar_ld_val = 16'h4444;
    #1 chk("R10 old value shown", addr_out, 16'h000F);
    idle();
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'h4444, "R8 ar load wins");
    // R8: selector load beats reselect
    @(negedge clk);
    req_ptr_wr = 1'b1; req_ptr_val = 3'd1; ptr_ld = 1'b1; ptr_ld_val = 3'd2;
    idle();
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'hFFFF, "R8 ptr load wins");

    // R9 stall
    @(negedge clk);
    req_valid = 1'b1; addr_ready = 1'b0; req_mode = 3'b010; req_ptr_wr = 1'b1; req_ptr_val = 3'd0;
    #1 chk("R9 ready follows", {15'd0, req_ready}, 16'd0);
    chk("R9 valid follows", {15'd0, addr_valid}, 16'd1);
    repeat (3) @(negedge clk);
    #1 chk("R9 held address", addr_out, 16'hFFFF);
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'hFFFF, "R9 no step when stalled");
    idle();
    #1 chk("R9 valid low", {15'd0, addr_valid}, 16'd0);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    xfer(3'b000, 7'h05, 1'b0, 3'd0, 16'h0005, "R1 page cleared");
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'h0000, "R1 regs cleared");
    idle();
    load_ar(3'd0, 16'h1111);
    xfer(3'b001, 7'h00, 1'b0, 3'd0, 16'h1111, "R1 selector cleared");
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule